// File: doc/BRIEF.md
# Selectable Timebase Event Generator

This block issues the timebase event that tells every performance-monitoring counter in the chip to capture a snapshot of its value and then clear. The event comes from exactly one of three sources. The first is an external input pin, which is synchronized and edge-detected. The second is a free-running internal interval counter with a programmable length. The third is a self-clearing trigger bit that software writes through the register port.

Software picks the source with two control bits. The first bit chooses between the outside world and an internal origin. The second bit only counts when the origin is internal, and it chooses between the interval counter and the software trigger. Whenever the event is generated internally, the block also drives its timebase output pin high for a stretch of cycles, so that other devices can follow the same timebase. A sticky flag records that an event happened, and software clears it by writing a one to it.

Top module: `tbase_event_gen`

## Requirements
- R1: After reset, the control word reads 0. That means external source, timer select clear and flag clear. The interval register reads `PERIOD_RST`, and both `tb_event` and `tb_pin_out` are low.
- R2: In external mode, a rising edge on `ext_tb_in` gives one single-cycle `tb_event` pulse. If the input is first seen high at clock edge N+1, the pulse is high in the cycle after edge N+3. Holding the input high gives no further events.
- R3: An event taken from the external pin leaves `tb_pin_out` low.
- R4: In interval mode (control bit 0 = 1, bit 1 = 1), events repeat every L cycles, where L is the interval register value (values below 2 act as 2). The first event arrives L cycles after the write that enters the mode.
- R5: Any write to the control word (address 0) or to the interval register (address 1) restarts the interval count. The next event then arrives a full interval after that write.
- R6: In software mode (bit 0 = 1, bit 1 = 0), a control write with bit 2 set gives one event in the cycle after the write. Bit 2 always reads back as 0.
- R7: Bit 2 has no effect when the written control value selects external or interval mode.
- R8: `ext_tb_in` is ignored in both internal modes. Bit 1 is ignored while bit 0 is 0, so the block stays in external mode.
- R9: Each internally generated event drives `tb_pin_out` high for `STRETCH` cycles, starting in the same cycle as `tb_event`.
- R10: Control bit 3 is a sticky event flag. Every event sets it, and writing 1 to it clears it. If an event and a clear arrive in the same cycle, the event wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address: 0 control, 1 interval |
| reg_wdata | input | PERIOD_W | Write data |
| reg_rdata | output | PERIOD_W | Read data for `reg_addr` (combinational) |
| ext_tb_in | input | 1 | External timebase input, asynchronous |
| tb_event | output | 1 | One-cycle snapshot-and-clear event |
| tb_pin_out | output | 1 | Stretched timebase pin output |

## Verification
The bench builds the block with `PERIOD_RST` = 37 and keeps the default `STRETCH` of 16. With the reset interval that short, the free-running mode can be entered without first programming the interval, so the reset value is observed as real event spacing. A reprogrammed interval of 20 cycles, which is longer than the stretch, lets the bench see the pin fall between events, and a restart in the middle of an interval is visible within a few dozen cycles.

// File: rtl/tbg_pkg.sv
package tbg_pkg;

  typedef enum logic [1:0] {
    SRC_EXT  = 2'd0,
    SRC_FREE = 2'd1,
    SRC_SOFT = 2'd2
  } src_e;

  localparam int CTRL_INT_BIT   = 0;
  localparam int CTRL_TIMER_BIT = 1;
  localparam int CTRL_FIRE_BIT  = 2;
  localparam int CTRL_FLAG_BIT  = 3;

  localparam int ADDR_CTRL   = 0;
  localparam int ADDR_PERIOD = 1;

  // Source decode: the timer choice only counts once the origin is internal.
  function automatic src_e pick_src(input logic internal_sel, input logic timer_sel);
    if (!internal_sel) return SRC_EXT;
    return timer_sel ? SRC_FREE : SRC_SOFT;
  endfunction

  // Effective interval length: shorter values are raised to two cycles.
  function automatic logic [31:0] eff_len(input logic [31:0] p);
    return (p < 32'd2) ? 32'd2 : p;
  endfunction

endpackage

// File: rtl/tbg_regs.sv
module tbg_regs #(
  parameter int          PERIOD_W   = 27,
  parameter int          ADDR_W     = 2,
  parameter int unsigned PERIOD_RST = 32'h04A28600
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [PERIOD_W-1:0] wdata,
  output logic [PERIOD_W-1:0] rdata,
  input  logic                evt_in,
  output logic                src_int,
  output logic                use_timer,
  output logic [PERIOD_W-1:0] period,
  output logic                fire_q,
  output logic                reload,
  output logic                sticky
);
  import tbg_pkg::*;

  logic ctrl_wr, period_wr;

  assign ctrl_wr   = we && (addr == ADDR_W'(ADDR_CTRL));
  assign period_wr = we && (addr == ADDR_W'(ADDR_PERIOD));
  assign reload    = ctrl_wr || period_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_int   <= 1'b0;
      use_timer <= 1'b0;
      period    <= PERIOD_W'(PERIOD_RST);
      fire_q    <= 1'b0;
      sticky    <= 1'b0;
    end else begin
      fire_q <= ctrl_wr && wdata[CTRL_FIRE_BIT];
      if (ctrl_wr) begin
        src_int   <= wdata[CTRL_INT_BIT];
        use_timer <= wdata[CTRL_TIMER_BIT];
      end
      if (period_wr) period <= wdata;
      if (evt_in)                              sticky <= 1'b1;
      else if (ctrl_wr && wdata[CTRL_FLAG_BIT]) sticky <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(ADDR_CTRL)) begin
      rdata[CTRL_INT_BIT]   = src_int;
      rdata[CTRL_TIMER_BIT] = use_timer;
      rdata[CTRL_FLAG_BIT]  = sticky;
    end else if (addr == ADDR_W'(ADDR_PERIOD)) begin
      rdata = period;
    end
  end

  AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n) evt_in |=> sticky); // R10

endmodule

// File: rtl/tbg_ext_sync.sv
module tbg_ext_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= async_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain[STAGES-1];

  assign rise = chain[STAGES-1] && !last_q;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) rise |=> !rise); // R2

endmodule

// File: rtl/tbg_interval.sv
module tbg_interval #(
  parameter int PERIOD_W = 27
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                reload,
  input  logic [PERIOD_W-1:0] period,
  output logic                expire
);
  import tbg_pkg::*;

  logic [PERIOD_W-1:0] cnt;
  logic [31:0]         last_val;
  logic                at_end;

  assign last_val = eff_len(32'(period)) - 32'd1;
  assign at_end   = 32'(cnt) >= last_val;
  assign expire   = run && !reload && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (reload || !run)     cnt <= '0;
    else if (at_end)             cnt <= '0;
    else                         cnt <= cnt + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) 32'(cnt) <= eff_len(32'(period)) - 32'd1 || $past(reload)); // R4
  AST_RELOAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) reload |=> cnt == '0); // R5

endmodule

// File: rtl/tbg_stretch.sv
module tbg_stretch #(
  parameter int STRETCH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic pin
);
  localparam int SW = $clog2(STRETCH + 1);

  logic [SW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             left <= '0;
    else if (trig)          left <= SW'(STRETCH);
    else if (left != '0)    left <= left - 1'b1;
  end

  assign pin = (left != '0);

  AST_PIN_ON_TRIG: assert property (@(posedge clk) disable iff (!rst_n) trig |=> pin); // R9
  AST_PIN_NO_SPUR: assert property (@(posedge clk) disable iff (!rst_n) (!pin && !trig) |=> !pin); // R3

endmodule

// File: rtl/tbase_event_gen.sv
module tbase_event_gen #(
  parameter int          PERIOD_W    = 27,
  parameter int          ADDR_W      = 2,
  parameter int unsigned PERIOD_RST  = 32'h04A28600,
  parameter int          STRETCH     = 16,
  parameter int          SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [PERIOD_W-1:0] reg_wdata,
  output logic [PERIOD_W-1:0] reg_rdata,
  input  logic                ext_tb_in,
  output logic                tb_event,
  output logic                tb_pin_out
);
  import tbg_pkg::*;

  logic                src_int, use_timer, fire_q, reload, sticky;
  logic [PERIOD_W-1:0] period;
  logic                ext_rise, expire;
  src_e                mode;
  logic                ext_evt, free_evt, soft_evt, int_evt, any_evt;

  tbg_regs #(.PERIOD_W(PERIOD_W), .ADDR_W(ADDR_W), .PERIOD_RST(PERIOD_RST)) regs_i (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .evt_in(tb_event), .src_int(src_int), .use_timer(use_timer),
    .period(period), .fire_q(fire_q), .reload(reload), .sticky(sticky)
  );

  tbg_ext_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .async_in(ext_tb_in), .rise(ext_rise)
  );

  assign mode = pick_src(src_int, use_timer);

  tbg_interval #(.PERIOD_W(PERIOD_W)) ivl_i (
    .clk(clk), .rst_n(rst_n), .run(mode == SRC_FREE), .reload(reload),
    .period(period), .expire(expire)
  );

  assign ext_evt  = (mode == SRC_EXT)  && ext_rise;
  assign free_evt = expire;
  assign soft_evt = (mode == SRC_SOFT) && fire_q;
  assign int_evt  = free_evt || soft_evt;
  assign any_evt  = ext_evt || int_evt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tb_event <= 1'b0;
    else        tb_event <= any_evt;

  tbg_stretch #(.STRETCH(STRETCH)) str_i (
    .clk(clk), .rst_n(rst_n), .trig(int_evt), .pin(tb_pin_out)
  );

  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) $countones({ext_evt, free_evt, soft_evt}) <= 1); // R8
  AST_EVT_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n) tb_event |=> sticky); // R10

endmodule

// File: tb/tbase_event_gen_tb.sv
module tbase_event_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PW  = 27;
  localparam int AW  = 2;
  localparam int PR  = 37;
  localparam int STR = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [PW-1:0] reg_wdata = '0;
  logic [PW-1:0] reg_rdata;
  logic          ext_tb_in = 1'b0;
  logic          tb_event, tb_pin_out;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int exp_cyc[$];
  string exp_req[$];

  tbase_event_gen #(.PERIOD_W(PW), .ADDR_W(AW), .PERIOD_RST(PR), .STRETCH(STR)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_tb_in(ext_tb_in),
    .tb_event(tb_event), .tb_pin_out(tb_pin_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Monitor: every event must match the head of the expected queue.
  always @(negedge clk) begin
    if (rst_n && tb_event) begin
      if (exp_cyc.size() == 0) begin
        check(1'b0, "R7/R8", "unexpected event at cycle", cyc, -1);
      end else begin
        automatic int e = exp_cyc.pop_front();
        automatic string r = exp_req.pop_front();
        check(cyc == e, r, "event cycle", cyc, e);
      end
    end
  end

  always @(negedge clk) begin
    if (cyc > 5000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected <5000", cyc);
      summary();
    end
  end

  task automatic expect_evt(input int c, input string r);
    exp_cyc.push_back(c);
    exp_req.push_back(r);
  endtask

  task automatic wr(input int a, input int d, output int w);
    reg_addr = AW'(a); reg_wdata = PW'(d); reg_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
    w = cyc;
  endtask

  task automatic rd(input int a, output int d);
    reg_addr = AW'(a);
    #1;
    d = int'(reg_rdata);
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  initial begin
    int w, w2, d, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(0, d); check(d == 0, "R1", "ctrl reset", d, 0);
    rd(1, d); check(d == PR, "R1", "interval reset", d, PR);
    check(tb_event == 0 && tb_pin_out == 0, "R1", "outputs reset", int'(tb_event), 0);

    // R4 free mode with reset interval
    wr(0, 3, w);
    expect_evt(w + PR, "R4");
    expect_evt(w + 2*PR, "R4");
    wait_to(w + PR);
    check(tb_pin_out == 1, "R9", "pin at event", int'(tb_pin_out), 1);
    wait_to(w + PR + STR - 1);
    check(tb_pin_out == 1, "R9", "pin last stretch cycle", int'(tb_pin_out), 1);
    wait_to(w + PR + STR);
    check(tb_pin_out == 0, "R9", "pin after stretch", int'(tb_pin_out), 0);
    wait_to(w + 2*PR + 2);
    // R5 reload by interval write mid-count
    wr(1, 20, w2);
    expect_evt(w2 + 20, "R5");
    expect_evt(w2 + 40, "R4");
    wait_to(w2 + 45);
    wr(0, 0, w);
    wait_to(w + 30);
    check(exp_cyc.size() == 0, "R4", "pending free events", exp_cyc.size(), 0);

    // R10 sticky flag
    rd(0, d); check(d[3] == 1, "R10", "flag set", d[3], 1);
    wr(0, 8, w);
    rd(0, d); check(d[3] == 0, "R10", "flag cleared", d[3], 0);

    // R2/R3 external edges
    n = cyc; ext_tb_in = 1'b1;
    expect_evt(n + 3, "R2");
    wait_to(n + 3);
    check(tb_pin_out == 0, "R3", "pin in ext mode", int'(tb_pin_out), 0);
    wait_to(n + 12);
    ext_tb_in = 1'b0;
    wait_to(n + 18);
    n = cyc; ext_tb_in = 1'b1;
    expect_evt(n + 3, "R2");
    wait_to(n + 8);
    ext_tb_in = 1'b0;

    // R8 timer bit ignored without internal bit; R7 fire ignored in ext
    wr(0, 2, w);
    wr(0, 4, w);
    wait_to(w + 60);
    n = cyc; ext_tb_in = 1'b1;
    expect_evt(n + 3, "R8");
    wait_to(n + 8);
    ext_tb_in = 1'b0;
    wait_to(n + 12);
    check(exp_cyc.size() == 0, "R8", "ext mode kept", exp_cyc.size(), 0);

    // R6 software trigger
    wr(0, 1, w);
    wait_to(w + 3);
    wr(0, 5, w);
    expect_evt(w + 1, "R6");
    rd(0, d); check(d[2] == 0, "R6", "fire reads 0", d[2], 0);
    wait_to(w + 1);
    check(tb_pin_out == 1, "R9", "pin on soft event", int'(tb_pin_out), 1);
    wait_to(w + 1 + STR);
    check(tb_pin_out == 0, "R9", "pin soft stretch end", int'(tb_pin_out), 0);
    wr(0, 5, w);
    expect_evt(w + 1, "R6");
    wait_to(w + 4);

    // R8 ext ignored in soft mode
    ext_tb_in = 1'b1;
    wait_to(w + 14);
    ext_tb_in = 1'b0;
    wait_to(w + 20);
    check(exp_cyc.size() == 0, "R8", "ext ignored in soft", exp_cyc.size(), 0);

    // R7 fire ignored when entering free mode
    wr(1, 25, w);
    wr(0, 7, w);
    expect_evt(w + 25, "R7");
    wait_to(w + 30);
    wr(0, 0, w);
    wait_to(w + 40);
    check(exp_cyc.size() == 0, "R7", "all expected events seen", exp_cyc.size(), 0);
    summary();
  end
endmodule